// File: doc/BRIEF.md
# Serial Flash Sector Lock Write Path

This block is the slave-side command logic that lets a host change the volatile protection bits of a serial flash. It shifts in a single-bit serial stream while chip select is low and keeps a write enable latch. It also holds a two-bit lock register for every sector: a write-lock bit and a lock-down bit. A write-enable command sets the latch. A lock-write command made of an opcode, a 24-bit address and one data byte then loads the lock register of the sector the address falls in. The array, the program and erase engines and any multi-bit I/O modes live elsewhere. The busy state of those engines arrives on an input.

The block runs on the serial clock and samples the data input on its rising edge. A command is decided on the first rising edge at which chip select is seen high. The frame length and opcode must be exact, and the latch, busy and lock-down state must allow it. Any other chip select rise drops the command with no effect. A read port returns any sector's two lock bits so that neighbouring logic can check protection.

Top module: `flash_lock_wr`

## Requirements
- R1: After reset every sector's lock bits are 0 and the write enable latch (wel_o) is 0.
- R2: A frame of exactly 8 bits carrying opcode 06h, sent MSB first and followed by chip select going high, sets the write enable latch.
- R3: A lock write is opcode E5h, then a 24-bit address, then a data byte, all MSB first (40 bits). When accepted, data bit 0 becomes the sector's write-lock bit (rd_lock_o[0]) and data bit 1 its lock-down bit (rd_lock_o[1]). The sector is address bits 22..16. All other address bits are ignored.
- R4: A lock write is rejected with no effect when the write enable latch is 0.
- R5: A lock write whose chip select rises after any bit count other than 40 has no effect on lock bits or on the latch.
- R6: A lock write that completes while busy_i is 1 has no effect on lock bits or on the latch.
- R7: A lock write whose data bits 7..2 are not all zero is rejected with no effect.
- R8: An accepted lock write clears the write enable latch.
- R9: Once a sector's lock-down bit is 1, further lock writes to that sector are rejected with no effect until reset.
- R10: Opcodes other than 06h and E5h have no effect, and an accepted lock write changes no sector other than the addressed one.
- R11: rd_lock_o shows the lock bits of the sector selected by rd_sector_i in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Serial clock; data sampled on rising edge |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cs_ni | input | 1 | Active-low chip select |
| sdi_i | input | 1 | Serial data input |
| busy_i | input | 1 | Program, erase or write cycle in progress |
| rd_sector_i | input | 7 | Sector index for the read port |
| rd_lock_o | output | 2 | Selected sector's lock bits: [1] lock-down, [0] write-lock |
| wel_o | output | 1 | Write enable latch |

## Verification
The assertions check on every cycle that the bit counter clears on chip select high and advances by one while selected. They also check that no lock write fires while busy, that the latch is clear after a lock write, and that the latch only rises on a chip select high edge. Per sector, they check that the lock-down bit is sticky and that a sector changes only when it is the write target. The bench's scenarios must show the rest: exact frame framing at 39, 40 and 41 bits, opcode and data-byte decoding, that the address bits outside 22..16 are ignored across all 128 sectors, and the read port's values.

// File: rtl/lock_pkg.sv
package lock_pkg;
  localparam logic [7:0] OP_WREN   = 8'h06;
  localparam logic [7:0] OP_WRLOCK = 8'hE5;
  localparam int OP_BITS    = 8;
  localparam int ADDR_BITS  = 24;
  localparam int DATA_BITS  = 8;
  localparam int FRAME_BITS = OP_BITS + ADDR_BITS + DATA_BITS;

  typedef struct packed {
    logic down;   // lock-down
    logic wlock;  // write-lock
  } lock_t;
endpackage

// File: rtl/lock_spi_shift.sv
module lock_spi_shift #(
  parameter int FRAME_BITS = 40,
  parameter int CNT_W      = 6
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  cs_ni,
  input  logic                  sdi_i,
  output logic [FRAME_BITS-1:0] frame_o,
  output logic [CNT_W-1:0]      cnt_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [FRAME_BITS-1:0] sr_q;
  logic [CNT_W-1:0]      cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q  <= '0;
      cnt_q <= '0;
    end else if (cs_ni) begin
      cnt_q <= '0;
    end else begin
      sr_q <= {sr_q[FRAME_BITS-2:0], sdi_i};
      if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;  // saturate: long frames stay invalid
    end
  end

  assign frame_o = sr_q;
  assign cnt_o   = cnt_q;

  // R5: counter clears whenever chip select is seen high
  a_r5_cnt_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_ni |=> cnt_q == '0);
  // R5: counter advances one per selected bit until saturation
  a_r5_cnt_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cs_ni && cnt_q != CNT_MAX) |=> cnt_q == $past(cnt_q) + 1'b1);
endmodule

// File: rtl/lock_cmd_decode.sv
module lock_cmd_decode
  import lock_pkg::*;
#(
  parameter int CNT_W      = 6,
  parameter int SEC_W      = 7,
  parameter int SECTOR_LSB = 16
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  cs_ni,
  input  logic                  busy_i,
  input  logic [FRAME_BITS-1:0] frame_i,
  input  logic [CNT_W-1:0]      cnt_i,
  input  logic                  down_i,
  output logic [SEC_W-1:0]      sel_o,
  output logic                  wr_en_o,
  output lock_t                 wr_val_o,
  output logic                  wel_o
);
  logic [OP_BITS-1:0]   op_long, op_short;
  logic [ADDR_BITS-1:0] addr;
  logic [DATA_BITS-1:0] data;
  logic                 wel_q, is_wren, is_lock_frame, data_ok;

  assign op_long  = frame_i[FRAME_BITS-1 -: OP_BITS];
  assign addr     = frame_i[DATA_BITS +: ADDR_BITS];
  assign data     = frame_i[DATA_BITS-1:0];
  assign op_short = frame_i[OP_BITS-1:0];

  assign sel_o    = addr[SECTOR_LSB +: SEC_W];
  assign data_ok  = (data[DATA_BITS-1:2] == '0);
  assign wr_val_o = '{down: data[1], wlock: data[0]};

  // decisions are taken on the first edge with chip select high
  assign is_wren       = cs_ni && (cnt_i == CNT_W'(OP_BITS)) && (op_short == OP_WREN);
  assign is_lock_frame = cs_ni && (cnt_i == CNT_W'(FRAME_BITS)) && (op_long == OP_WRLOCK);
  assign wr_en_o       = is_lock_frame && wel_q && !busy_i && data_ok && !down_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      wel_q <= 1'b0;
    else if (wr_en_o) wel_q <= 1'b0;
    else if (is_wren) wel_q <= 1'b1;
  end

  assign wel_o = wel_q;

  // R8: latch is clear after an accepted lock write
  a_r8_wel_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |=> !wel_q);
  // R6: no lock write while busy
  a_r6_busy_block: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |-> !wr_en_o);
  // R2: latch rises only on a chip select high edge
  a_r2_wel_on_cs: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(wel_q) |-> $past(cs_ni));
endmodule

// File: rtl/lock_array.sv
module lock_array
  import lock_pkg::*;
#(
  parameter int NUM_SECTORS = 128,
  parameter int SEC_W       = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [SEC_W-1:0] wr_sel_i,
  input  lock_t            wr_val_i,
  input  logic [SEC_W-1:0] rd_sel_i,
  output lock_t            rd_o,
  output logic             down_o
);
  lock_t lock_q [NUM_SECTORS];

  for (genvar g = 0; g < NUM_SECTORS; g++) begin : g_sec
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) lock_q[g] <= '0;
      else if (wr_en_i && wr_sel_i == SEC_W'(g) && !lock_q[g].down) lock_q[g] <= wr_val_i;
    end

    // R9: lock-down is sticky until reset
    a_r9_down_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
      lock_q[g].down |=> lock_q[g].down);
    // R10: only the addressed sector may change
    a_r10_only_target: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(wr_en_i && wr_sel_i == SEC_W'(g)) |=> $stable(lock_q[g]));
  end

  assign rd_o   = lock_q[rd_sel_i];
  assign down_o = lock_q[wr_sel_i].down;
endmodule

// File: rtl/flash_lock_wr.sv
module flash_lock_wr
  import lock_pkg::*;
#(
  parameter int NUM_SECTORS = 128,
  parameter int SECTOR_LSB  = 16,
  localparam int SEC_W      = $clog2(NUM_SECTORS),
  localparam int CNT_W      = $clog2(FRAME_BITS + 2)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cs_ni,
  input  logic             sdi_i,
  input  logic             busy_i,
  input  logic [SEC_W-1:0] rd_sector_i,
  output logic [1:0]       rd_lock_o,
  output logic             wel_o
);
  logic [FRAME_BITS-1:0] frame;
  logic [CNT_W-1:0]      cnt;
  logic [SEC_W-1:0]      sel;
  logic                  wr_en, down;
  lock_t                 wr_val, rd_val;

  lock_spi_shift #(.FRAME_BITS(FRAME_BITS), .CNT_W(CNT_W)) i_shift (
    .clk_i, .rst_ni, .cs_ni, .sdi_i, .frame_o(frame), .cnt_o(cnt)
  );

  lock_cmd_decode #(.CNT_W(CNT_W), .SEC_W(SEC_W), .SECTOR_LSB(SECTOR_LSB)) i_dec (
    .clk_i, .rst_ni, .cs_ni, .busy_i, .frame_i(frame), .cnt_i(cnt), .down_i(down),
    .sel_o(sel), .wr_en_o(wr_en), .wr_val_o(wr_val), .wel_o
  );

  lock_array #(.NUM_SECTORS(NUM_SECTORS), .SEC_W(SEC_W)) i_arr (
    .clk_i, .rst_ni, .wr_en_i(wr_en), .wr_sel_i(sel), .wr_val_i(wr_val),
    .rd_sel_i(rd_sector_i), .rd_o(rd_val), .down_o(down)
  );

  assign rd_lock_o = rd_val;
endmodule

// File: tb/test_flash_lock_wr.sv
module test_flash_lock_wr;
  logic clk = 1'b0, rst_n = 1'b0, cs_n = 1'b1, sdi = 1'b0, busy = 1'b0;
  logic [6:0] rd_sec = '0;
  logic [1:0] rd_lock;
  logic       wel;
  int checks = 0, errors = 0;
  logic [1:0] model [128];

  always #10 clk = ~clk;

  flash_lock_wr i_flash_lock_wr (
    .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_n), .sdi_i(sdi), .busy_i(busy),
    .rd_sector_i(rd_sec), .rd_lock_o(rd_lock), .wel_o(wel)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // v is left-aligned; n bits are sent MSB first
  task automatic send(input logic [47:0] v, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); cs_n = 1'b0; sdi = v[47-i];
    end
    @(negedge clk); cs_n = 1'b1; sdi = 1'b0;
    @(negedge clk);
  endtask

  function automatic logic [47:0] lk(input logic [7:0] op, input logic [23:0] a, input logic [7:0] d);
    return {op, a, d, 8'h00};
  endfunction

  task automatic wren();
    send({8'h06, 40'h0}, 8);
  endtask

  task automatic chk_sec(input int s, input string tag);
    rd_sec = 7'(s); #2;
    check(tag, int'(rd_lock), int'(model[s]));
  endtask

  task automatic chk_all(input string tag);
    for (int s = 0; s < 128; s++) chk_sec(s, tag);
  endtask

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int s = 0; s < 128; s++) model[s] = 2'b00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 wel after reset", int'(wel), 0);
    chk_all("R1 lock after reset");

    // R4: no latch
    send(lk(8'hE5, 24'h05_0000, 8'h01), 40);
    chk_sec(5, "R4 no wel");
    check("R4 wel", int'(wel), 0);

    // R2
    wren();
    check("R2 wel set", int'(wel), 1);

    // R5: wrong lengths
    send(lk(8'hE5, 24'h05_0000, 8'h01), 39);
    chk_sec(5, "R5 39 bits");
    send(lk(8'hE5, 24'h05_0000, 8'h01), 41);
    chk_sec(5, "R5 41 bits");
    send(lk(8'hE5, 24'h05_0000, 8'h01), 7);
    check("R5 wel kept", int'(wel), 1);

    // R6: busy
    busy = 1'b1;
    send(lk(8'hE5, 24'h05_0000, 8'h01), 40);
    busy = 1'b0;
    chk_sec(5, "R6 busy");
    check("R6 wel kept", int'(wel), 1);

    // R7: nonzero upper data bits
    send(lk(8'hE5, 24'h05_0000, 8'h05), 40);
    chk_sec(5, "R7 bad data");
    check("R7 wel kept", int'(wel), 1);

    // R10: foreign opcode
    send(lk(8'hE4, 24'h05_0000, 8'h01), 40);
    chk_sec(5, "R10 foreign op");
    check("R10 wel kept", int'(wel), 1);

    // R3/R8 sweep over every sector with varied ignored address bits
    for (int s = 0; s < 128; s++) begin
      logic [23:0] a;
      a = {s[0], 7'(s), 16'((s * 517) & 16'hFFFF)};
      wren();
      send(lk(8'hE5, a, {7'b0, s[1]}), 40);
      model[s] = {1'b0, s[1]};
      check("R8 wel cleared", int'(wel), 0);
    end
    chk_all("R3 sweep");

    // R9: lock-down on sector 3, down-only on sector 4
    wren();
    send(lk(8'hE5, 24'h03_1234, 8'h03), 40);
    model[3] = 2'b11;
    chk_sec(3, "R9 set down");
    wren();
    send(lk(8'hE5, 24'h03_0000, 8'h00), 40);
    chk_sec(3, "R9 sticky");
    check("R9 reject keeps wel", int'(wel), 1);
    send(lk(8'hE5, 24'h04_0000, 8'h02), 40);
    model[4] = 2'b10;
    chk_sec(4, "R9 down only");
    wren();
    send(lk(8'hE5, 24'h04_0000, 8'h01), 40);
    chk_sec(4, "R9 sticky 4");
    chk_all("R10 others intact");

    // R11: read port follows selection within the cycle
    rd_sec = 7'd3; #1;
    check("R11 read 3", int'(rd_lock), 3);
    rd_sec = 7'd4; #1;
    check("R11 read 4", int'(rd_lock), 2);

    // R1/R9: reset clears lock-down
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    for (int s = 0; s < 128; s++) model[s] = 2'b00;
    check("R1 wel after second reset", int'(wel), 0);
    chk_all("R9 reset clears");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule